// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block sits beside a small 8-bit processor core and decides, at each instruction boundary, whether the core must divert into an interrupt handler and which handler it must run. It keeps a pending-flag register that peripheral request pulses set, and an enable-mask register. It also keeps a single master enable that gates all dispatch. The core reads and writes both registers at two fixed bus addresses.

When the core signals a boundary, the master enable is set and at least one source is both pending and enabled, the unit selects the lowest-numbered such source. On the same edge it clears that source's flag bit and the master enable, and it offers a dispatch token on a valid/ready port. The token carries the handler's fixed vector. It asks the core to push the current program counter and to jump there, as a call would. The token stays on the port with a stable vector until the core accepts it with `disp_ready`. While a token waits, boundaries start no new dispatch, so the core may stall acceptance for as long as it needs. EI, DI and return-from-interrupt pulses from the decoder control the master enable. Stack handling and decoding stay in the core.

Top module: `irq_dispatch_unit`

## Requirements
- R1: After reset both registers read 0x00, the master enable is clear and `disp_valid` is low.
- R2: The pending-flag register is at address 0xFF0F and the enable-mask register is at 0xFFFF. A write with `bus_wr` high updates bits [4:0] at the next edge. Bits [7:5] always read as 0. `bus_rdata` shows the addressed register without delay and reads 0x00 at any other address.
- R3: A high bit of `irq_pulse` sets the matching flag bit at the next edge, including when the core writes a 0 to that bit in the same cycle.
- R4: A dispatch starts only on an edge where `boundary` is high, the master enable is set, (flags & mask) is non-zero and `disp_valid` is low.
- R5: The lowest-numbered pending and enabled source is served. Source n has vector 0x40 + 8·n, so bit 0 gives 0x40 and bit 4 gives 0x60.
- R6: At the dispatch edge the served flag bit clears, the other flag bits are kept, the master enable clears and `disp_valid` goes high with the vector.
- R7: While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and `disp_vector` stays stable. The flags are not altered by further boundaries. The token leaves on the edge where `disp_ready` is high.
- R8: `cmd_ei` and `cmd_reti` set the master enable and `cmd_di` clears it. When DI and EI arrive in the same cycle, DI wins.
- R9: If a source's request pulse arrives on the edge that dispatches that same source, the flag bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse | input | 5 | One-cycle request pulses from peripherals, one per source |
| bus_addr | input | 16 | Core bus address |
| bus_wr | input | 1 | Core write strobe |
| bus_wdata | input | 8 | Core write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cmd_ei | input | 1 | Set the master enable |
| cmd_di | input | 1 | Clear the master enable |
| cmd_reti | input | 1 | Return from interrupt: set the master enable |
| boundary | input | 1 | Core is about to fetch the next instruction |
| disp_valid | output | 1 | Dispatch token offered: push the program counter and jump |
| disp_vector | output | 16 | Handler address of the offered token |
| disp_ready | input | 1 | Core accepts the token |

## Verification
The checker watches four things on every cycle. It checks that the offered token holds still under back-pressure. It checks that every token vector lies on the legal vector grid. It checks that a new token only follows a boundary that came while the master enable was set. It also checks that the master enable is clear whenever a token appears and after every DI. The bench alone shows which source wins among several pending ones. It also shows how the flag register resolves a clash between a request, a write and a dispatch clear, and that the upper bits and unmapped addresses read as zero. To show these, it compares the bus reads and the port against a reference model under random stimulus and in directed cases.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // handler address of source idx on an evenly spaced vector grid
  function automatic addr_t vec_addr(addr_t base, int unsigned stride, int unsigned idx);
    return base + addr_t'(stride * idx);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
// N-bit register: load by write, then per-bit clear, then per-bit set (set wins)
module irq_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  logic [N-1:0] loaded;
  logic [N-1:0] nxt;

  always_comb begin
    loaded = wr_en ? wdata : q;
    nxt    = (loaded & ~clr) | set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_prio_pick.sv
// lowest index wins
module irq_prio_pick #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot[i]  = pend[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | pend[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_master_en.sv
// priority: dispatch entry > DI > EI/RETI
module irq_master_en (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic di,
  input  logic ei,
  input  logic reti,
  output logic ime
);
  always_ff @(posedge clk) begin
    if (!rst_n)          ime <= 1'b0;
    else if (take)       ime <= 1'b0;
    else if (di)         ime <= 1'b0;
    else if (ei || reti) ime <= 1'b1;
  end
endmodule

// File: rtl/irq_vector_port.sv
module irq_vector_port
  import irq_dispatch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_vec,
  input  logic  ready,
  output logic  valid,
  output addr_t vector
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vector <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      vector <= load_vec;
    end else if (valid && ready) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 5,
  parameter logic [15:0] VEC_BASE    = 16'h0040,
  parameter int unsigned VEC_STRIDE  = 8,
  parameter logic [15:0] FLAG_ADDR   = 16'hFF0F,
  parameter logic [15:0] MASK_ADDR   = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_pulse,
  input  logic [15:0]        bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               cmd_ei,
  input  logic               cmd_di,
  input  logic               cmd_reti,
  input  logic               boundary,
  output logic               disp_valid,
  output logic [15:0]        disp_vector,
  input  logic               disp_ready
);
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] flags_q, mask_q, pend, pick_oh, flag_clr;
  logic [IW-1:0]      pick_idx;
  logic               pick_any, ime_q, take;
  logic               wr_flag, wr_mask;
  addr_t              pick_vec;

  assign wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
  assign wr_mask = bus_wr && (bus_addr == MASK_ADDR);

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_flag), .wdata(bus_wdata[NUM_SRC-1:0]),
    .clr(flag_clr), .set(irq_pulse), .q(flags_q)
  );

  irq_flag_bank #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask), .wdata(bus_wdata[NUM_SRC-1:0]),
    .clr('0), .set('0), .q(mask_q)
  );

  assign pend = flags_q & mask_q;

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .pend(pend), .any(pick_any), .onehot(pick_oh), .idx(pick_idx)
  );

  assign take     = boundary && ime_q && pick_any && !disp_valid;
  assign flag_clr = take ? pick_oh : '0;
  assign pick_vec = vec_addr(VEC_BASE, VEC_STRIDE, int'(pick_idx));

  irq_master_en u_ime (
    .clk(clk), .rst_n(rst_n), .take(take), .di(cmd_di), .ei(cmd_ei),
    .reti(cmd_reti), .ime(ime_q)
  );

  irq_vector_port u_port (
    .clk(clk), .rst_n(rst_n), .load(take), .load_vec(pick_vec),
    .ready(disp_ready), .valid(disp_valid), .vector(disp_vector)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == FLAG_ADDR)      bus_rdata[NUM_SRC-1:0] = flags_q;
    else if (bus_addr == MASK_ADDR) bus_rdata[NUM_SRC-1:0] = mask_q;
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int unsigned NUM_SRC    = 5,
  parameter logic [15:0] VEC_BASE   = 16'h0040,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        cmd_di,
  input logic        ime,
  input logic        disp_valid,
  input logic        disp_ready,
  input logic [15:0] disp_vector
);
  localparam logic [15:0] VEC_END = VEC_BASE + 16'(NUM_SRC * VEC_STRIDE);

  AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_vector)); // R7

  AST_VECTOR_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_vector >= VEC_BASE) && (disp_vector < VEC_END)
                   && (((disp_vector - VEC_BASE) % 16'(VEC_STRIDE)) == 16'd0)); // R5

  AST_GATED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> $past(ime) && $past(boundary)); // R4

  AST_ENTRY_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> !ime); // R6

  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> !ime); // R8
endmodule

bind irq_dispatch_unit irq_dispatch_chk #(
  .NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .cmd_di(cmd_di), .ime(ime_q),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_vector(disp_vector)
);

// File: tb/tb_irq_dispatch_unit.sv
`timescale 1ns/1ps
module tb_irq_dispatch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  irq_pulse;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        cmd_ei, cmd_di, cmd_reti, boundary;
  logic        disp_valid, disp_ready;
  logic [15:0] disp_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_dispatch_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti), .boundary(boundary),
    .disp_valid(disp_valid), .disp_vector(disp_vector), .disp_ready(disp_ready)
  );

  // reference model state
  logic [4:0]  m_if, m_ie;
  logic        m_ime, m_v;
  logic [15:0] m_vec;

  function automatic logic [15:0] exp_vec(input logic [4:0] p);
    for (int i = 0; i < 5; i++) if (p[i]) return 16'h0040 + 16'(8 * i);
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_pulse = '0; bus_addr = 16'h0000; bus_wr = 0; bus_wdata = '0;
    cmd_ei = 0; cmd_di = 0; cmd_reti = 0; boundary = 0; disp_ready = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    bus_addr = a; bus_wr = 0; #0.2; v = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d; step();
  endtask

  // model update from the inputs present before the edge
  task automatic model_step();
    logic [4:0] pend, oh, nif;
    logic tk;
    pend = m_if & m_ie;
    oh = '0;
    for (int i = 0; i < 5; i++) if (pend[i] && oh == 0) oh[i] = 1'b1;
    tk = boundary && m_ime && (pend != 0) && !m_v;
    nif = (bus_wr && bus_addr == 16'hFF0F) ? bus_wdata[4:0] : m_if;
    if (tk) nif = nif & ~oh;
    nif = nif | irq_pulse;
    if (bus_wr && bus_addr == 16'hFFFF) m_ie = bus_wdata[4:0];
    m_if = nif;
    if (tk) m_ime = 0; else if (cmd_di) m_ime = 0; else if (cmd_ei || cmd_reti) m_ime = 1;
    if (tk) begin m_v = 1; m_vec = exp_vec(pend); end
    else if (m_v && disp_ready) m_v = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(16'hFF0F, v); chk("R1 flags", v, 8'h00);
    rd(16'hFFFF, v); chk("R1 mask", v, 8'h00);
    chk("R1 valid", disp_valid, 0);

    // R2 register access
    wr(16'hFFFF, 8'hFF);
    rd(16'hFFFF, v); chk("R2 mask upper bits zero", v, 8'h1F);
    wr(16'hFF0F, 8'hFE);
    rd(16'hFF0F, v); chk("R2 flags readback", v, 8'h1E);
    rd(16'h1234, v); chk("R2 unmapped reads zero", v, 8'h00);

    // R4 no dispatch with master enable clear
    boundary = 1; step();
    chk("R4 blocked without ime", disp_valid, 0);

    // R5/R6/R7 dispatch bit1 under back-pressure
    cmd_ei = 1; step();
    boundary = 1; step();
    chk("R5 valid", disp_valid, 1);
    chk("R5 vector bit1", disp_vector, 16'h0048);
    rd(16'hFF0F, v); chk("R6 served bit cleared", v, 8'h1C);
    boundary = 1; step();
    chk("R7 vector held", disp_vector, 16'h0048);
    rd(16'hFF0F, v); chk("R7 flags untouched", v, 8'h1C);
    disp_ready = 1; step();
    chk("R7 token accepted", disp_valid, 0);

    // R6 ime cleared at entry; R8 reti restores it
    boundary = 1; step();
    chk("R6 ime cleared", disp_valid, 0);
    cmd_reti = 1; step();
    boundary = 1; step();
    chk("R8 reti then vector bit2", disp_vector, 16'h0050);
    disp_ready = 1; step();

    // R8 DI wins over EI
    cmd_ei = 1; cmd_di = 1; step();
    boundary = 1; step();
    chk("R8 di wins", disp_valid, 0);

    // R3 request beats write
    irq_pulse = 5'b01000; bus_addr = 16'hFF0F; bus_wr = 1; bus_wdata = 8'h00; step();
    rd(16'hFF0F, v); chk("R3 request beats write", v, 8'h08);
    irq_pulse = 5'b00001; step();
    rd(16'hFF0F, v); chk("R3 pulse sets bit0", v, 8'h09);

    // R9 same-source request during dispatch
    cmd_ei = 1; step();
    boundary = 1; irq_pulse = 5'b00001; step();
    chk("R9 vector bit0", disp_vector, 16'h0040);
    rd(16'hFF0F, v); chk("R9 bit kept", v, 8'h09);
    disp_ready = 1; step();

    // random phase against the model
    m_if = 5'h09; m_ie = 5'h1F; m_ime = 0; m_v = 0; m_vec = 16'h0040;
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      irq_pulse = (($urandom % 6) == 0) ? 5'($urandom) : 5'h00;
      bus_wr    = (($urandom % 8) == 0);
      bus_addr  = ($urandom % 2) ? 16'hFF0F : 16'hFFFF;
      bus_wdata = 8'($urandom);
      cmd_ei    = (($urandom % 5) == 0);
      cmd_di    = (($urandom % 9) == 0);
      cmd_reti  = (($urandom % 7) == 0);
      boundary  = (($urandom % 3) != 0);
      disp_ready = (($urandom % 2) == 0);
      model_step();
      step();
      chk("R5 rand valid", disp_valid, m_v);
      if (m_v) chk("R5 rand vector", disp_vector, m_vec);
      rd(16'hFF0F, v); chk("R3 rand flags", v, {3'b0, m_if});
      rd(16'hFFFF, v); chk("R2 rand mask", v, {3'b0, m_ie});
      bus_addr = 16'h0000;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule